// File: doc/BRIEF.md
# Bidirectional GPIO Port Pair with Grouped Pull-ups and Key Wake-up

This block holds two 8-bit general-purpose pin ports, A and B. Each port has a per-pin direction register and an output latch. A pin marked as output drives its latch value and enables its pad driver. A pin marked as input leaves the pad undriven. In that case its level is brought in through a two-stage synchronizer and returned on register reads. Writing the latch of an input pin only stores the value, which appears on the pad once the pin is switched to output.

One shared 8-bit pull control register turns on the pad pull-ups by groups of pins across both ports. An output pin never has its pull-up enabled. A key wake-up detector watches the synchronized levels of the input pins of port A. When the AND of those levels drops from 1 to 0, it issues a one-cycle request.

Software reaches the registers through a plain register bus: address, write data, write strobe, and a read data output that is combinational from the address. The bus has no handshake and never stalls, so no back-pressure applies. The pin inputs, pad controls and the wake-up pulse are plain level signals.

Top module: `gpkw_top`

## Requirements
- R1: After reset, both direction registers and both latches are 0, the pull control register is 0xFF, every oe output is 0 and every pu output is 1.
- R2: Direction bit 1 makes the pin an output: its oe output is 1 and its out output equals the latch bit. Direction bit 0 gives oe 0.
- R3: Reading a port's data register returns the latch bit for every output pin, whatever the pad level.
- R4: Reading a port's data register returns the pad level for every input pin. The level is valid once the pad has been stable for two clock edges.
- R5: Writing the data register updates only the latch of an input pin. Its oe stays 0 and its read value stays the pad level. The stored value drives the pin once the pin becomes an output.
- R6: Pull control bit 0 covers A0, bit 1 covers A1, bit 2 covers A2 and A3, and bit 3 covers A4 to A7. A bit value of 1 means pull-up on.
- R7: Pull control bit 4 covers B0 to B3, bit 5 covers B4, bit 6 covers B5 and B6, and bit 7 covers B7.
- R8: An output pin has its pu output at 0 whatever its pull control bit says.
- R9: When the synchronized AND of port A's input pins goes from 1 to 0, wake_o is high for exactly one cycle. If the pads change before clock edge k, the pulse is visible after edge k+2.
- R10: Output pins of port A are left out of the wake-up AND, and port B never causes a wake-up.
- R11: The register addresses are 0 for the port A data, 1 for the port A direction, 2 for the port B data, 3 for the port B direction and 4 for the pull control. Reads of addresses 5 to 7 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 8 | Read data for addr_i |
| a_pin_i | input | 8 | Port A pad levels |
| a_out_o | output | 8 | Port A pad output data |
| a_oe_o | output | 8 | Port A pad output enables |
| a_pu_o | output | 8 | Port A pull-up enables |
| b_pin_i | input | 8 | Port B pad levels |
| b_out_o | output | 8 | Port B pad output data |
| b_oe_o | output | 8 | Port B pad output enables |
| b_pu_o | output | 8 | Port B pull-up enables |
| wake_o | output | 1 | One-cycle key wake-up request |

## Verification
The assertions assume that the pad inputs reach the synchronizer as asynchronous levels. They also assume that the write strobe and address are stable around the clock edge. The bench drives every input only at falling edges, so both assumptions hold. It mixes seeded random register writes and pad patterns with directed wake-up sequences. After each pad change it waits at least three edges before comparing reads, so the two-stage synchronizer has settled.

// File: rtl/gpkw_pkg.sv
package gpkw_pkg;
  localparam int PORT_W = 8;
  localparam int CTRL_W = 8;
  localparam int ADDR_W = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    RA_DATA = 3'd0,
    RA_DIR  = 3'd1,
    RB_DATA = 3'd2,
    RB_DIR  = 3'd3,
    R_PULL  = 3'd4
  } reg_addr_e;

  // Pull control group index for a pin; port_b selects port B.
  function automatic int pull_group(input bit port_b, input int pin);
    if (!port_b) begin
      if (pin < 2) return pin;
      else if (pin < 4) return 2;
      else return 3;
    end else begin
      if (pin < 4) return 4;
      else if (pin == 4) return 5;
      else if (pin < 7) return 6;
      else return 7;
    end
  endfunction
endpackage

// File: rtl/gpkw_port.sv
module gpkw_port #(
  parameter int W = 8,
  parameter int SYNC = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic         data_we_i,
  input  logic         dir_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] latch_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] view_o
);
  logic [W-1:0] stage_q [SYNC];

  generate
    for (genvar s = 0; s < SYNC; s++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '1;
        else if (s == 0) stage_q[s] <= pin_i;
        else stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '0;
      dir_o   <= '0;
    end else begin
      if (data_we_i) latch_o <= wdata_i;
      if (dir_we_i)  dir_o   <= wdata_i;
    end
  end

  assign view_o = (dir_o & latch_o) | (~dir_o & sync_o);

  // R5: a data write lands in the latch for all pins
  p_latch_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> latch_o == $past(wdata_i));
  // R2: a direction write sets the direction bits
  p_dir_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_we_i |=> dir_o == $past(wdata_i));
  // R5: latch holds without a data write
  p_latch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_we_i |=> $stable(latch_o));
endmodule

// File: rtl/gpkw_pull.sv
module gpkw_pull
  import gpkw_pkg::*;
#(
  parameter int W = PORT_W,
  parameter int CW = CTRL_W
) (
  input  logic [CW-1:0] ctrl_i,
  input  logic [W-1:0]  a_dir_i,
  input  logic [W-1:0]  b_dir_i,
  output logic [W-1:0]  a_pu_o,
  output logic [W-1:0]  b_pu_o
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      localparam int GA = pull_group(1'b0, i);
      localparam int GB = pull_group(1'b1, i);
      assign a_pu_o[i] = ctrl_i[GA] & ~a_dir_i[i];
      assign b_pu_o[i] = ctrl_i[GB] & ~b_dir_i[i];
    end
  endgenerate
endmodule

// File: rtl/gpkw_keywake.sv
module gpkw_keywake #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] dir_i,
  output logic         wake_o
);
  logic and_now, and_q;

  // output pins count as 1 so they never pull the AND low
  assign and_now = &(sync_i | dir_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      and_q  <= 1'b1;
      wake_o <= 1'b0;
    end else begin
      and_q  <= and_now;
      wake_o <= and_q & ~and_now;
    end
  end

  // R9: request lasts one cycle only
  p_wake_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);
  // R9: a request leaves the stored AND low
  p_wake_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> !and_q);
  // R10: all-output port cannot raise a request
  p_all_out_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&dir_i && $past(&dir_i)) |=> !wake_o);
endmodule

// File: rtl/gpkw_top.sv
module gpkw_top
  import gpkw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [PORT_W-1:0] rdata_o,
  input  logic [PORT_W-1:0] a_pin_i,
  output logic [PORT_W-1:0] a_out_o,
  output logic [PORT_W-1:0] a_oe_o,
  output logic [PORT_W-1:0] a_pu_o,
  input  logic [PORT_W-1:0] b_pin_i,
  output logic [PORT_W-1:0] b_out_o,
  output logic [PORT_W-1:0] b_oe_o,
  output logic [PORT_W-1:0] b_pu_o,
  output logic              wake_o
);
  logic [CTRL_W-1:0] pull_q;
  logic [PORT_W-1:0] a_sync, b_sync, a_view, b_view;

  gpkw_port #(.W(PORT_W), .SYNC(SYNC_STAGES)) port_a_i (
    .clk_i, .rst_ni, .pin_i(a_pin_i),
    .data_we_i(we_i && addr_i == RA_DATA),
    .dir_we_i(we_i && addr_i == RA_DIR),
    .wdata_i, .latch_o(a_out_o), .dir_o(a_oe_o),
    .sync_o(a_sync), .view_o(a_view));

  gpkw_port #(.W(PORT_W), .SYNC(SYNC_STAGES)) port_b_i (
    .clk_i, .rst_ni, .pin_i(b_pin_i),
    .data_we_i(we_i && addr_i == RB_DATA),
    .dir_we_i(we_i && addr_i == RB_DIR),
    .wdata_i, .latch_o(b_out_o), .dir_o(b_oe_o),
    .sync_o(b_sync), .view_o(b_view));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pull_q <= '1;
    else if (we_i && addr_i == R_PULL) pull_q <= wdata_i;
  end

  gpkw_pull #(.W(PORT_W), .CW(CTRL_W)) pull_i (
    .ctrl_i(pull_q), .a_dir_i(a_oe_o), .b_dir_i(b_oe_o),
    .a_pu_o, .b_pu_o);

  gpkw_keywake #(.W(PORT_W)) wake_i (
    .clk_i, .rst_ni, .sync_i(a_sync), .dir_i(a_oe_o), .wake_o);

  always_comb begin
    case (addr_i)
      RA_DATA: rdata_o = a_view;
      RA_DIR:  rdata_o = a_oe_o;
      RB_DATA: rdata_o = b_view;
      RB_DIR:  rdata_o = b_oe_o;
      R_PULL:  rdata_o = pull_q;
      default: rdata_o = '0;
    endcase
  end

  // R8: no pin both drives and pulls up
  p_pull_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_oe_o & a_pu_o) == '0) && ((b_oe_o & b_pu_o) == '0));
  // R3: output pins read back their latch
  p_read_out_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == RA_DATA) |-> ((rdata_o & a_oe_o) == (a_out_o & a_oe_o)));
  // R11: unmapped addresses read as zero
  p_unmapped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > 3'd4) |-> rdata_o == '0);
  // R11: pull control written only at its own address
  p_pull_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == R_PULL) |=> $stable(pull_q));
endmodule

// File: tb/gpkw_top_tb_top.sv
`timescale 1ns/1ps
module gpkw_top_tb_top;
  logic       clk = 0, rst_n = 0, we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, rdata, a_pin = 8'hFF, b_pin = 8'hFF;
  logic [7:0] a_out, a_oe, a_pu, b_out, b_oe, b_pu;
  logic       wake;
  int checks = 0, fails = 0;
  logic [7:0] m_adir = 0, m_alat = 0, m_bdir = 0, m_blat = 0, m_pull = 8'hFF;

  always #5 clk = ~clk;

  gpkw_top dut_i (.clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .rdata_o(rdata), .a_pin_i(a_pin), .a_out_o(a_out), .a_oe_o(a_oe),
    .a_pu_o(a_pu), .b_pin_i(b_pin), .b_out_o(b_out), .b_oe_o(b_oe), .b_pu_o(b_pu),
    .wake_o(wake));

  function automatic logic [7:0] exp_pu_a(logic [7:0] p, logic [7:0] d);
    return {{4{p[3]}}, {2{p[2]}}, p[1], p[0]} & ~d;
  endfunction
  function automatic logic [7:0] exp_pu_b(logic [7:0] p, logic [7:0] d);
    return {p[7], {2{p[6]}}, p[5], {4{p[4]}}} & ~d;
  endfunction
  function automatic logic [7:0] exp_view(logic [7:0] d, logic [7:0] l, logic [7:0] p);
    return (d & l) | (~d & p);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
    case (a)
      3'd0: m_alat = d; 3'd1: m_adir = d; 3'd2: m_blat = d;
      3'd3: m_bdir = d; 3'd4: m_pull = d; default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic check_all();
    logic [7:0] v;
    chk("R2 a_oe", a_oe, m_adir); chk("R2 b_oe", b_oe, m_bdir);
    chk("R2 a_out", a_out, m_alat); chk("R2 b_out", b_out, m_blat);
    chk("R6/R8 a_pu", a_pu, exp_pu_a(m_pull, m_adir));
    chk("R7/R8 b_pu", b_pu, exp_pu_b(m_pull, m_bdir));
    rd(3'd0, v); chk("R3/R4 read A", v, exp_view(m_adir, m_alat, a_pin));
    rd(3'd2, v); chk("R3/R4 read B", v, exp_view(m_bdir, m_blat, b_pin));
    rd(3'd4, v); chk("R11 read pull", v, m_pull);
  endtask

  // counts wake cycles over n sampled cycles, returns index of first
  task automatic watch_wake(int n, output int cnt, output int first);
    cnt = 0; first = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wake) begin cnt++; if (first < 0) first = i; end
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int cnt, first;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 a_oe", a_oe, 8'h00); chk("R1 b_oe", b_oe, 8'h00);
    chk("R1 a_out", a_out, 8'h00); chk("R1 a_pu", a_pu, 8'hFF);
    chk("R1 b_pu", b_pu, 8'hFF); rd(3'd4, v); chk("R1 pull", v, 8'hFF);
    chk("R1 wake", {7'd0, wake}, 8'h00);

    // R5 latch write on input pins: oe stays 0, read is pad
    a_pin = 8'h3C;
    wr(3'd0, 8'hA5);
    repeat (3) @(negedge clk);
    chk("R5 oe stays", a_oe, 8'h00);
    rd(3'd0, v); chk("R5 read pad", v, 8'h3C);
    wr(3'd1, 8'hFF);
    chk("R5 latch drives", a_out, 8'hA5);
    rd(3'd0, v); chk("R3 read latch", v, 8'hA5);

    // R6/R7 each pull bit alone, all inputs
    wr(3'd1, 8'h00);
    for (int g = 0; g < 8; g++) begin
      wr(3'd4, 8'h01 << g);
      chk("R6 a_pu group", a_pu, exp_pu_a(8'h01 << g, 8'h00));
      chk("R7 b_pu group", b_pu, exp_pu_b(8'h01 << g, 8'h00));
    end
    // R8 outputs forced off
    wr(3'd4, 8'hFF); wr(3'd3, 8'h0F);
    chk("R8 b_pu", b_pu, 8'hF0);

    // R11 unmapped addresses
    wr(3'd6, 8'h77);
    rd(3'd6, v); chk("R11 unmapped read", v, 8'h00);
    rd(3'd4, v); chk("R11 pull unchanged", v, 8'hFF);
    rd(3'd3, v); chk("R11 dirB unchanged", v, 8'h0F);

    // R9 wake on falling AND
    wr(3'd1, 8'h00);
    a_pin = 8'hFF; repeat (4) @(negedge clk);
    a_pin = 8'hFE;
    watch_wake(6, cnt, first);
    chk("R9 wake count", cnt[7:0], 8'd1);
    chk("R9 wake timing", first[7:0], 8'd2);
    a_pin = 8'hFF; watch_wake(5, cnt, first);
    chk("R9 rising no wake", cnt[7:0], 8'd0);
    // R10 output pin excluded
    wr(3'd1, 8'h01);
    a_pin = 8'hFE; watch_wake(5, cnt, first);
    chk("R10 output pin ignored", cnt[7:0], 8'd0);
    a_pin = 8'hFF; wr(3'd1, 8'h00); repeat (4) @(negedge clk);
    // R10 port B ignored
    b_pin = 8'h00; watch_wake(5, cnt, first);
    chk("R10 port B ignored", cnt[7:0], 8'd0);

    // random mix (R2 R3 R4 R6 R7 R8)
    for (int n = 0; n < 300; n++) begin
      wr(3'($urandom_range(0, 4)), 8'($urandom));
      @(negedge clk);
      a_pin = 8'($urandom); b_pin = 8'($urandom);
      repeat (3) @(negedge clk);
      check_all();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule